// File: doc/BRIEF.md
# Sampled-Channel Converter Controller with Interlocked Result Registers

This block sequences a 10-bit successive-approximation converter and owns the registers that software reads the samples from. A write to the control register picks an input channel and starts a conversion. The converter is reached through a one-cycle start pulse with a channel number, and it answers with a done strobe and a sample. The block can restart conversions on its own (continuous mode). It can also hold back results that fail a programmable threshold test.

The result sits in a high register and a low register. In 10-bit mode, reading the high register first freezes both registers until the low register is read, so the two halves always belong to the same sample. Any conversion that finishes while the registers are frozen is dropped. In 8-bit mode the result is the top eight sample bits and the registers are never frozen. A complete flag, which can be masked onto an interrupt line, tells software that a fresh sample is waiting.

Top module: `sar_ctl_top`

## Requirements
- R1: A write to address 0 captures the channel from bits [3:0] and the interrupt enable from bit 6. In the next cycle `conv_start` is high for exactly one cycle, with `conv_chan` equal to the written channel.
- R2: `conv_chan` changes only when address 0 is written.
- R3: In continuous mode (address 1 bit 1 = 1), an accepted `conv_done` raises `conv_start` in the following cycle on the same channel. In single mode the conversion ends, and any `conv_done` that arrives while no conversion is running is ignored.
- R4: Address 5 reads result bits [7:0] and address 4 reads result bits [9:8] in its bits [1:0]. In 8-bit mode (address 1 bit 0 = 0) the result is sample bits [9:2], and address 4 reads 0.
- R5: When compare is enabled (address 1 bit 2 = 1), a result is stored only if it passes the test. With address 1 bit 3 = 1 the test is result >= threshold; otherwise it is result < threshold. The threshold is address 2 (bits [7:0]) together with address 3 bits [1:0] (bits [9:8]). A failing sample leaves the registers and the flag unchanged.
- R6: In 10-bit mode, reading address 4 blocks all result transfers until address 5 is read. Samples that complete while blocked are lost and do not set the flag.
- R7: In 8-bit mode, reading address 4 does not block later transfers.
- R8: A write to address 1 that changes bit 0 clears both result registers to zero and releases the block.
- R9: The complete flag (address 0 bit 7) is set on a transfer. It is cleared by a read of address 5 or by a write of address 0. A transfer in the same cycle as the clearing read wins.
- R10: `irq` is high exactly when the complete flag and the interrupt enable are both set.
- R11: A write to address 0 during a conversion aborts it and starts a new one. A `conv_done` arriving in the same cycle as that write is discarded.
- R12: After reset all registers read zero, `conv_start` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | CHAN_W | Channel to convert |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 10 | Converter sample |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Two pairs of events can land in the same clock edge. A `conv_done` can coincide with a restart write to the control register. A new sample can also arrive while the high half has already been read. The bench forces the first collision by raising `conv_done` and the address-0 write in one cycle. It then judges the outcome at the ports: the flag stays clear, a fresh start pulse carries the new channel, and the result afterwards is the next sample rather than the colliding one. For the second, it reads the high half, delivers a sample, and confirms that the low half still returns the old byte and that the blocked sample never appears later.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  localparam int SMP_W = 10;
  localparam int BYTE_W = 8;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_THL  = 3'd2;
  localparam logic [2:0] A_THH  = 3'd3;
  localparam logic [2:0] A_RHI  = 3'd4;
  localparam logic [2:0] A_RLO  = 3'd5;

  // Result as stored: full sample in 10-bit mode, top byte otherwise.
  function automatic logic [SMP_W-1:0] fmt_sample(input logic [SMP_W-1:0] s,
                                                  input logic wide);
    return wide ? s : (s >> (SMP_W - BYTE_W));
  endfunction

  function automatic logic cmp_pass(input logic [SMP_W-1:0] r,
                                    input logic [SMP_W-1:0] thr,
                                    input logic en, input logic ge);
    if (!en) return 1'b1;
    return ge ? (r >= thr) : (r < thr);
  endfunction
endpackage

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              cont,
  input  logic              done_in,
  output logic              done_acc,
  output logic              busy,
  output logic              start_pls,
  output logic [CHAN_W-1:0] chan
);
  // a restart in the same cycle drops the finishing sample
  assign done_acc = done_in && busy && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      start_pls <= 1'b0;
      chan      <= '0;
    end else if (restart) begin
      busy      <= 1'b1;
      start_pls <= 1'b1;
      chan      <= chan_in;
    end else if (done_acc) begin
      busy      <= cont;
      start_pls <= cont;
    end else begin
      start_pls <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank
  import sar_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_acc,
  input  logic [SMP_W-1:0] sample,
  input  logic             wide,
  input  logic             cmp_en,
  input  logic             cmp_ge,
  input  logic [SMP_W-1:0] thr,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic             clr_flag,
  input  logic             mode_chg,
  output logic [SMP_W-1:0] res,
  output logic             lock,
  output logic             flag,
  output logic             xfer
);
  logic [SMP_W-1:0] cand;

  assign cand = fmt_sample(sample, wide);
  assign xfer = done_acc && !lock && !mode_chg && cmp_pass(cand, thr, cmp_en, cmp_ge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res  <= '0;
      lock <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (mode_chg)  res <= '0;
      else if (xfer) res <= cand;

      if (mode_chg || rd_lo) lock <= 1'b0;
      else if (rd_hi && wide) lock <= 1'b1;

      if (xfer) flag <= 1'b1;
      else if (rd_lo || clr_flag) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_ctl_top.sv
module sar_ctl_top
  import sar_ctl_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [SMP_W-1:0]  conv_data,
  output logic              irq
);
  localparam int PAD_W = 6 - CHAN_W;
  localparam int HI_W  = SMP_W - BYTE_W;

  logic [3:0]       cfg_q;
  logic             ie_q;
  logic [SMP_W-1:0] thr_q;

  // named events for the checker
  logic ctrl_wr_ev, cfg_wr_ev, mode_chg_ev, rd_hi_ev, rd_lo_ev;
  logic done_acc, busy_q, xfer_ev, lock_q, flag_q;
  logic [SMP_W-1:0] res_q;

  assign ctrl_wr_ev  = bus_wr && (bus_addr == A_CTRL);
  assign cfg_wr_ev   = bus_wr && (bus_addr == A_CFG);
  assign mode_chg_ev = cfg_wr_ev && (bus_wdata[0] != cfg_q[0]);
  assign rd_hi_ev    = bus_rd && (bus_addr == A_RHI);
  assign rd_lo_ev    = bus_rd && (bus_addr == A_RLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ie_q  <= 1'b0;
      thr_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ie_q <= bus_wdata[6];
        A_CFG:   cfg_q <= bus_wdata[3:0];
        A_THL:   thr_q[BYTE_W-1:0] <= bus_wdata;
        A_THH:   thr_q[SMP_W-1:BYTE_W] <= bus_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  sar_conv_seq #(.CHAN_W(CHAN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .restart(ctrl_wr_ev), .chan_in(bus_wdata[CHAN_W-1:0]),
    .cont(cfg_q[1]), .done_in(conv_done),
    .done_acc(done_acc), .busy(busy_q),
    .start_pls(conv_start), .chan(conv_chan)
  );

  sar_result_bank u_res (
    .clk(clk), .rst_n(rst_n),
    .done_acc(done_acc), .sample(conv_data),
    .wide(cfg_q[0]), .cmp_en(cfg_q[2]), .cmp_ge(cfg_q[3]), .thr(thr_q),
    .rd_hi(rd_hi_ev), .rd_lo(rd_lo_ev), .clr_flag(ctrl_wr_ev),
    .mode_chg(mode_chg_ev),
    .res(res_q), .lock(lock_q), .flag(flag_q), .xfer(xfer_ev)
  );

  assign irq = flag_q && ie_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {flag_q, ie_q, {PAD_W{1'b0}}, conv_chan};
      A_CFG:   bus_rdata = {4'b0, cfg_q};
      A_THL:   bus_rdata = thr_q[BYTE_W-1:0];
      A_THH:   bus_rdata = {{(BYTE_W-HI_W){1'b0}}, thr_q[SMP_W-1:BYTE_W]};
      A_RHI:   bus_rdata = {{(BYTE_W-HI_W){1'b0}}, res_q[SMP_W-1:BYTE_W]};
      A_RLO:   bus_rdata = res_q[BYTE_W-1:0];
      default: bus_rdata = '0;
    endcase
  end
endmodule

module sar_ctl_chk #(
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr_ev,
  input logic              mode_chg_ev,
  input logic              done_acc,
  input logic              xfer_ev,
  input logic              cont,
  input logic              wide,
  input logic              busy_q,
  input logic              conv_done,
  input logic              conv_start,
  input logic [CHAN_W-1:0] conv_chan,
  input logic              lock_q,
  input logic              flag_q,
  input logic [9:0]        res_q
);
  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_ev |=> $stable(conv_chan));
  // R3
  cont_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && cont) |=> conv_start);
  // R3
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy_q && !mode_chg_ev) |=> $stable(res_q));
  // R6
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !mode_chg_ev) |=> $stable(res_q));
  // R7
  narrow_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> !lock_q);
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ev |=> flag_q);
endmodule

bind sar_ctl_top sar_ctl_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr_ev(ctrl_wr_ev), .mode_chg_ev(mode_chg_ev),
  .done_acc(done_acc), .xfer_ev(xfer_ev), .cont(cfg_q[1]), .wide(cfg_q[0]),
  .busy_q(busy_q), .conv_done(conv_done), .conv_start(conv_start),
  .conv_chan(conv_chan), .lock_q(lock_q), .flag_q(flag_q), .res_q(res_q)
);

// File: tb/tb_sar_ctl_top.sv
module tb_sar_ctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       conv_start;
  logic [3:0] conv_chan;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       irq;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sar_ctl_top dut (.*);

  // {cfg, threshold, sample, exp_hi, exp_lo, exp_flag}
  localparam logic [34:0] VEC [8] = '{
    {4'h1, 10'h000, 10'h2A5, 2'd2, 8'hA5, 1'b1},
    {4'h0, 10'h000, 10'h2A5, 2'd0, 8'hA9, 1'b1},
    {4'hD, 10'h100, 10'h180, 2'd1, 8'h80, 1'b1},
    {4'hD, 10'h100, 10'h0FF, 2'd1, 8'h80, 1'b0},
    {4'h5, 10'h100, 10'h0FF, 2'd0, 8'hFF, 1'b1},
    {4'h5, 10'h100, 10'h100, 2'd0, 8'hFF, 1'b0},
    {4'hC, 10'h040, 10'h100, 2'd0, 8'h40, 1'b1},
    {4'h4, 10'h040, 10'h0FC, 2'd0, 8'h3F, 1'b1}
  };

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic done(input logic [9:0] s);
    @(negedge clk); conv_done = 1'b1; conv_data = s;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(3'd0, d); check("R12 ctrl", d, 0);
    rd(3'd4, d); check("R12 hi", d, 0);
    rd(3'd5, d); check("R12 lo", d, 0);
    check("R12 start", conv_start, 0);
    check("R12 irq", irq, 0);

    // R4 R5 table
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, {4'h0, VEC[i][34:31]});
      wr(3'd2, VEC[i][28:21]);
      wr(3'd3, {6'h0, VEC[i][30:29]});
      wr(3'd0, 8'h01);
      done(VEC[i][20:11]);
      rd(3'd0, d); check("R5/R9 flag", d[7], VEC[i][0]);
      rd(3'd4, d); check("R4/R5 hi", d, VEC[i][10:9]);
      rd(3'd5, d); check("R4/R5 lo", d, VEC[i][8:1]);
    end
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R1 start pulse and channel
    wr(3'd0, 8'h05);
    check("R1 start", conv_start, 1);
    check("R1 chan", conv_chan, 5);
    @(negedge clk); check("R1 one pulse", conv_start, 0);

    // R3 continuous then single
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h07);
    done(10'h123);
    check("R3 restart", conv_start, 1);
    check("R3 same chan", conv_chan, 7);
    wr(3'd1, 8'h01);
    done(10'h045);
    check("R3 single ends", conv_start, 0);
    done(10'h3FF);
    rd(3'd4, d); check("R3 idle done hi", d, 0);
    rd(3'd5, d); check("R3 idle done lo", d, 8'h45);

    // R6 interlock in 10-bit mode
    wr(3'd0, 8'h01);
    done(10'h111);
    rd(3'd4, d); check("R6 hi", d, 1);
    wr(3'd0, 8'h01);
    done(10'h3CC);
    rd(3'd0, d); check("R6 blocked flag", d[7], 0);
    rd(3'd5, d); check("R6 lo kept", d, 8'h11);
    wr(3'd0, 8'h01);
    done(10'h2EE);
    rd(3'd4, d); check("R6 next hi", d, 2);
    rd(3'd5, d); check("R6 next lo", d, 8'hEE);

    // R8 mode change clears; R7 no interlock in 8-bit
    wr(3'd1, 8'h02);
    rd(3'd4, d); check("R8 hi clear", d, 0);
    rd(3'd5, d); check("R8 lo clear", d, 0);
    wr(3'd0, 8'h02);
    done(10'h0F0);
    rd(3'd4, d); check("R7 hi", d, 0);
    done(10'h100);
    rd(3'd5, d); check("R7 lo updated", d, 8'h40);
    wr(3'd1, 8'h01);

    // R9 R10 flag and interrupt
    wr(3'd0, 8'h42);
    done(10'h0AB);
    check("R10 irq set", irq, 1);
    rd(3'd0, d); check("R9 flag set", d[7], 1);
    rd(3'd5, d);
    check("R10 irq clear on read", irq, 0);
    wr(3'd0, 8'h42);
    done(10'h010);
    check("R10 irq again", irq, 1);
    wr(3'd0, 8'h42);
    check("R9 ctrl write clears", irq, 0);

    // R9 transfer wins over same-cycle low read
    @(negedge clk); conv_done = 1'b1; conv_data = 10'h033;
    bus_rd = 1'b1; bus_addr = 3'd5;
    @(negedge clk); conv_done = 1'b0; bus_rd = 1'b0;
    rd(3'd0, d); check("R9 set wins", d[7], 1);

    // R11 abort collision
    wr(3'd0, 8'h42);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h43;
    conv_done = 1'b1; conv_data = 10'h155;
    @(negedge clk); bus_wr = 1'b0; conv_done = 1'b0;
    check("R11 restart pulse", conv_start, 1);
    check("R11 new chan", conv_chan, 3);
    rd(3'd0, d); check("R11 no flag", d[7], 0);
    rd(3'd5, d); check("R11 aborted dropped", d, 8'h33);
    done(10'h0AA);
    rd(3'd4, d); rd(3'd5, d2);
    check("R11 next hi", d, 0);
    check("R11 next lo", d2, 8'hAA);

    // R2 channel holds without control write
    wr(3'd1, 8'h01);
    repeat (4) @(negedge clk);
    check("R2 chan hold", conv_chan, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule